// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker and LCD Lane Mapper

This block sits between the frame-buffer word fetch and the panel timing logic. It takes 32-bit words through a valid/ready handshake and keeps their bytes in a small holding register. Each time the timing logic asks for a pixel, the block delivers one pixel on a 24-bit panel data bus. Three storage formats are supported. In the padded true-colour format, each word holds one pixel. In the packed true-colour format, pixels are stored back to back, so a pixel can span two words. In the 16-bit format, each word holds two pixels, and each pixel carries a shared intensity bit.

A lane mapper places the colour components on the bus. It can exchange the red and blue lanes for boards wired in the opposite colour order. It drives to zero every line that the selected format does not use. If a pixel is requested while fewer bytes than one pixel are held, the bus keeps its previous value and an underflow flag is raised.

A three-state fill machine tracks the holding register. ST_EMPTY holds no bytes. ST_PART holds some bytes, but fewer than one pixel. ST_AVAIL holds at least one complete pixel. The transitions are:
- fill: ST_EMPTY to ST_PART or ST_AVAIL, on an accepted word.
- complete: ST_PART to ST_AVAIL, when a word brings enough bytes.
- drain: ST_AVAIL to ST_EMPTY, when a pixel removal leaves no bytes.
- split: ST_AVAIL to ST_PART, when a removal leaves a partial pixel.

Top module: `fbpix_unpack`

## Requirements
- R1: While reset is active, lcd_data is 0, pix_underflow is 0 and word_ready is 1.
- R2: word_ready is 1 exactly when the holding register contains 4 bytes or fewer. A word is taken on a clock edge where word_valid and word_ready are both 1. Its bytes are queued behind the held bytes, least significant byte first.
- R3: With cfg_fmt 0 (padded true colour) or 3 (treated as padded), each pixel uses 4 queued bytes. The bytes map as follows: byte 0 (word bits 7:0) is red and goes to bus 7:0, byte 1 is green and goes to bus 15:8, byte 2 is blue and goes to bus 23:16. Byte 3 (word bits 31:24) has no effect.
- R4: With cfg_fmt 1 (packed true colour), each pixel uses 3 queued bytes in the order red, green, blue. Three words therefore yield four pixels, and pixels span word boundaries. The lane placement is the same as in R3.
- R5: With cfg_fmt 2 (16-bit), each pixel uses 2 queued bytes. The low half of a word comes before its high half. Pixel bits 4:0 (red) go to bus 7:3, bits 9:5 (green) to bus 15:11 and bits 14:10 (blue) to bus 23:19. Bit 15 (intensity) drives bus bits 2, 10 and 18. Bus bits 1:0, 9:8 and 17:16 are 0.
- R6: When cfg_swap is 1 as a pixel is taken, the red and blue lane contents are exchanged: red goes to the bus bits blue would use, and blue to the bits red would use. Green and the intensity bits are unchanged.
- R7: lcd_data changes only on the clock edge after a pix_en cycle that finds a complete pixel held. Pixels leave in storage order. In cycles without pix_en, lcd_data holds its value and pix_underflow is 0.
- R8: pix_en in a cycle where fewer bytes than one pixel are held sets pix_underflow to 1 for the next cycle. lcd_data keeps its value, and no bytes are consumed.
- R9: A word accepted in the same cycle as pix_en cannot serve that request. Availability depends only on the bytes held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Storage format: 0 padded, 1 packed, 2 16-bit, 3 as padded; change only during reset |
| cfg_swap | input | 1 | Exchange red and blue lanes |
| word_valid | input | 1 | Frame-buffer word offered |
| word_data | input | 32 | Frame-buffer word |
| word_ready | output | 1 | Block can take a word |
| pix_en | input | 1 | Pixel request from the timing logic |
| lcd_data | output | 24 | Panel data bus |
| pix_underflow | output | 1 | Previous request found no complete pixel |

## Verification
Word intake and pixel removal can fall in the same cycle. This matters most when the holding register is short of a pixel, and when a packed pixel straddles the incoming word. Random streams drive word_valid and pix_en independently across all formats, with the swap control toggling, so simultaneous push and pop happen at every fill level. Directed cases also hit the empty-register push-with-request case. A byte-queue model in the bench decides each outcome: a delivered pixel, an underflow with the bus held, or a readiness change. The model removes bytes before appending the new word, and it judges availability on the queue depth before the edge.

// File: rtl/fbpix_pkg.sv
package fbpix_pkg;

    typedef enum logic [1:0] {
        FMT_PAD24  = 2'd0,
        FMT_PACK24 = 2'd1,
        FMT_RGB16  = 2'd2,
        FMT_ALT    = 2'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_AVAIL = 2'd2
    } fill_st_e;

    // bytes removed from the holding register for one pixel
    function automatic logic [2:0] bytes_per_pix(input pix_fmt_e f);
        logic [2:0] n;
        unique case (f)
            FMT_PACK24: n = 3'd3;
            FMT_RGB16:  n = 3'd2;
            default:    n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fbpix_stage.sv
module fbpix_stage
    import fbpix_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int HOLD_BYTES = 2 * WORD_BYTES,
    parameter int HEAD_BYTES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pix_fmt_e                  fmt,
    input  logic                      word_valid,
    input  logic [WORD_BYTES*8-1:0]   word_data,
    output logic                      word_ready,
    input  logic                      pop,
    output logic                      pix_avail,
    output logic [HEAD_BYTES*8-1:0]   head
);

    localparam int HOLD_W = HOLD_BYTES * 8;
    localparam int CNT_W  = $clog2(HOLD_BYTES + 1);
    localparam int SH_W   = $clog2(HOLD_W + 1);
    localparam int ROOM   = HOLD_BYTES - WORD_BYTES;

    logic [HOLD_W-1:0] hold_q, hold_s, hold_n;
    logic [CNT_W-1:0]  cnt_q, cnt_s, cnt_n, need;
    fill_st_e          st_q, st_n;
    logic              accept, take;

    always_comb begin
        need       = CNT_W'(bytes_per_pix(fmt));
        pix_avail  = (st_q == ST_AVAIL);
        word_ready = (cnt_q <= CNT_W'(ROOM));
        accept     = word_valid && word_ready;
        take       = pop && pix_avail;
        head       = hold_q[HEAD_BYTES*8-1:0];
    end

    // byte queue: remove the head pixel first, then append the new word
    always_comb begin
        if (take) begin
            hold_s = hold_q >> (SH_W'(need) << 3);
            cnt_s  = cnt_q - need;
        end else begin
            hold_s = hold_q;
            cnt_s  = cnt_q;
        end
        if (accept) begin
            hold_n = hold_s | (HOLD_W'(word_data) << (SH_W'(cnt_s) << 3));
            cnt_n  = cnt_s + CNT_W'(WORD_BYTES);
        end else begin
            hold_n = hold_s;
            cnt_n  = cnt_s;
        end
    end

    // fill state transitions
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (accept)
                    st_n = (cnt_n >= need) ? ST_AVAIL : ST_PART;   // fill
            end
            ST_PART: begin
                if (cnt_n >= need)
                    st_n = ST_AVAIL;                               // complete
            end
            ST_AVAIL: begin
                if (cnt_n == '0)
                    st_n = ST_EMPTY;                               // drain
                else if (cnt_n < need)
                    st_n = ST_PART;                                // split
            end
            default: st_n = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_EMPTY;
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            hold_q <= hold_n;
        end
    end

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(HOLD_BYTES));

    // R8
    avail_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_avail |-> (cnt_q >= need));

    // R2
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY) |-> (word_ready && cnt_q == '0));

endmodule

// File: rtl/fbpix_lane_map.sv
module fbpix_lane_map
    import fbpix_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int LANE_W = 8,
    parameter int C16_W  = 5
) (
    input  pix_fmt_e                  fmt,
    input  logic                      swap,
    input  logic [LANES*LANE_W-1:0]   head,
    output logic [LANES*LANE_W-1:0]   bus
);

    localparam int I_POS  = LANES * C16_W;
    localparam int PAD16  = LANE_W - C16_W - 1;

    logic intens;
    assign intens = head[I_POS];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int SRC_N = k;
        localparam int SRC_S = LANES - 1 - k;

        logic [LANE_W-1:0] v24, v16;
        logic [C16_W-1:0]  c16;

        assign v24 = swap ? head[SRC_S*LANE_W +: LANE_W]
                          : head[SRC_N*LANE_W +: LANE_W];
        assign c16 = swap ? head[SRC_S*C16_W +: C16_W]
                          : head[SRC_N*C16_W +: C16_W];
        assign v16 = {c16, intens, {PAD16{1'b0}}};
        assign bus[k*LANE_W +: LANE_W] = (fmt == FMT_RGB16) ? v16 : v24;
    end

endmodule

// File: rtl/fbpix_unpack.sv
module fbpix_unpack
    import fbpix_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cfg_fmt,
    input  logic                    cfg_swap,
    input  logic                    word_valid,
    input  logic [WORD_W-1:0]       word_data,
    output logic                    word_ready,
    input  logic                    pix_en,
    output logic [LANES*LANE_W-1:0] lcd_data,
    output logic                    pix_underflow
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BUS_W      = LANES * LANE_W;

    pix_fmt_e         fmt;
    logic             pix_avail;
    logic [BUS_W-1:0] head;
    logic [BUS_W-1:0] mapped;

    assign fmt = pix_fmt_e'(cfg_fmt);

    fbpix_stage #(
        .WORD_BYTES (WORD_BYTES),
        .HOLD_BYTES (2 * WORD_BYTES),
        .HEAD_BYTES (BUS_W / 8)
    ) stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .pop        (pix_en),
        .pix_avail  (pix_avail),
        .head       (head)
    );

    fbpix_lane_map #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .C16_W  (5)
    ) map_i (
        .fmt  (fmt),
        .swap (cfg_swap),
        .head (head),
        .bus  (mapped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcd_data      <= '0;
            pix_underflow <= 1'b0;
        end else begin
            pix_underflow <= pix_en && !pix_avail;
            if (pix_en && pix_avail)
                lcd_data <= mapped;
        end
    end

    // R8
    uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !pix_avail) |=> (pix_underflow && $stable(lcd_data)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(lcd_data) && !pix_underflow));

    // R5
    unused_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_RGB16) |-> ((lcd_data & 24'h030303) == 24'h0));

    // R5
    intens_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_RGB16) |-> (lcd_data[18] == lcd_data[10] &&
                                lcd_data[10] == lcd_data[2]));

endmodule

// File: tb/fbpix_unpack_tb.sv
`timescale 1ns/1ps
module fbpix_unpack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_swap = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_en = 1'b0;
    logic [23:0] lcd_data;
    logic        pix_underflow;

    int unsigned total = 0;
    int unsigned bad = 0;

    logic [7:0]  q[$];
    logic [23:0] exp_lcd = '0;
    logic        exp_uf = 1'b0;
    string       exp_tag = "R1";
    logic        pending = 1'b0;

    always #2.5 clk = ~clk;

    fbpix_unpack dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_fmt       (cfg_fmt),
        .cfg_swap      (cfg_swap),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_ready    (word_ready),
        .pix_en        (pix_en),
        .lcd_data      (lcd_data),
        .pix_underflow (pix_underflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic int need_of(input logic [1:0] f);
        return (f == 2'd1) ? 3 : (f == 2'd2) ? 2 : 4;
    endfunction

    function automatic logic [23:0] exp_pix(input logic [1:0] f, input logic sw,
                                            input logic [23:0] h);
        logic [7:0] r, g, b;
        if (f == 2'd2) begin
            r = {h[4:0],   h[15], 2'b00};
            g = {h[9:5],   h[15], 2'b00};
            b = {h[14:10], h[15], 2'b00};
        end else begin
            r = h[7:0];
            g = h[15:8];
            b = h[23:16];
        end
        return sw ? {r, g, b} : {b, g, r};
    endfunction

    task automatic do_reset(input logic [1:0] f);
        @(negedge clk);
        rst_n = 1'b0; word_valid = 1'b0; pix_en = 1'b0; cfg_fmt = f;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {31'b0, word_ready}, 32'd1);
        chk("R1", {8'b0, lcd_data}, 32'd0);
        chk("R1", {31'b0, pix_underflow}, 32'd0);
        rst_n = 1'b1;
        q.delete();
        exp_lcd = '0; exp_uf = 1'b0; exp_tag = "R1"; pending = 1'b0;
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic pe, input logic sw);
        int n;
        logic [23:0] h;
        @(negedge clk);
        if (pending) begin
            chk(exp_tag, {8'b0, lcd_data}, {8'b0, exp_lcd});
            chk(exp_tag, {31'b0, pix_underflow}, {31'b0, exp_uf});
        end
        // R2 readiness from held byte count
        chk("R2", {31'b0, word_ready}, {31'b0, (q.size() <= 4)});
        word_valid = v; word_data = d; pix_en = pe; cfg_swap = sw;
        n = need_of(cfg_fmt);
        if (pe) begin
            if (q.size() >= n) begin
                h = '0;
                for (int i = 0; i < n && i < 3; i++) h[8*i +: 8] = q[i];
                exp_lcd = exp_pix(cfg_fmt, sw, h);
                exp_uf = 1'b0;
                for (int i = 0; i < n; i++) void'(q.pop_front());
                exp_tag = (cfg_fmt == 2'd1) ? (sw ? "R4 R6" : "R4")
                        : (cfg_fmt == 2'd2) ? (sw ? "R5 R6" : "R5")
                        : (sw ? "R3 R6" : "R3");
            end else begin
                exp_uf = 1'b1;
                exp_tag = v ? "R9" : "R8";
            end
        end else begin
            exp_uf = 1'b0;
            exp_tag = "R7";
        end
        if (v && word_ready)
            for (int i = 0; i < 4; i++) q.push_back(d[8*i +: 8]);
        pending = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));

        // R3: padded format, top byte must not matter
        do_reset(2'd0);
        step(1, 32'hAB123456, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        step(1, 32'hFF0A0B0C, 0, 1);
        step(0, 0, 1, 1);
        step(0, 0, 0, 0);

        // R4: three packed words give four pixels
        do_reset(2'd1);
        step(1, 32'h44332211, 0, 0);
        step(1, 32'h88776655, 1, 0);
        step(0, 0, 1, 0);
        step(1, 32'hCCBBAA99, 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);

        // R5: two pixels per word, intensity set in one half only
        do_reset(2'd2);
        step(1, 32'h7FFF8000, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        step(0, 0, 1, 0);

        // R9: empty register, push and request together
        do_reset(2'd1);
        step(1, 32'h00C0FFEE, 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);

        // random streams in every format
        for (int f = 0; f < 4; f++) begin
            do_reset(f[1:0]);
            for (int c = 0; c < 3000; c++)
                step(($urandom % 4) != 0, $urandom, ($urandom % 3) != 0, ($urandom % 5) == 0);
            step(0, 0, 0, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule